// File: doc/BRIEF.md
# Bus Clock Divider Factor Search

This block picks the two fields of a two-stage serial-bus clock divider: a linear factor M (0 to 15) and an exponent N (0 to 7). The bus rate for a candidate pair is the core clock divided by ten, by (M + 1), and by a power of two set by N. The engine walks every candidate and keeps the one whose rate comes closest to a requested rate without going above it. A configuration sequencer pulses `start_i` with the core clock rate, the wanted bus rate and the exponent convention. It then waits for `done_o` and copies the packed field value into its divider control register.

All of the arithmetic runs through one shared multi-cycle restoring divider, so a full sweep of 128 candidates takes a few thousand cycles. The search stops early when a candidate hits the request exactly. The block has no data stream, so every pin is plain control or status and there is no back-pressure. The three inputs are captured on the start pulse. The results stay fixed from `done_o` until the next accepted start.

Top module: `busclk_factor_search`

## Requirements
- R1: With `base0_i` low, the candidate rate is floor(core / (10 * (M + 1) * 2^(N + 1))).
- R2: With `base0_i` high, the power-of-two term is 2^N instead of 2^(N + 1).
- R3: Candidates are visited with N outer from 0 to 7 and M inner from 0 to 15. A candidate replaces the kept one only when target minus rate is at least zero and strictly below the kept difference, so on a tie the earliest candidate wins.
- R4: The sweep ends on the first candidate whose difference is exactly zero. For an exact hit at M = 0, N = 0, `done_o` arrives within 60 cycles of the start pulse.
- R5: If no candidate has a rate at or below the target, `found_o` is 0 and `m_o`, `n_o` and `div_reg_o` are all 0.
- R6: `div_reg_o` packs the result with N in bits 2:0 and M in bits 6:3.
- R7: `busy_o` is high from the cycle after an accepted start until the cycle of `done_o`. `done_o` is a one-cycle pulse, and `busy_o` is low while it is high.
- R8: A start pulse while `busy_o` is high is ignored. Inputs that change during a search do not affect its result.
- R9: `found_o`, `m_o`, `n_o` and `div_reg_o` stay constant from `done_o` until the next accepted start.
- R10: After reset, `busy_o`, `done_o` and `found_o` are 0, and `m_o`, `n_o` and `div_reg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; ignored while busy |
| core_hz_i | input | 32 | Core clock rate in Hz |
| target_hz_i | input | 32 | Requested bus rate in Hz |
| base0_i | input | 1 | Exponent convention: 1 selects 2^N, 0 selects 2^(N+1) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | A candidate at or below the target exists |
| m_o | output | 4 | Chosen linear factor M |
| n_o | output | 3 | Chosen exponent N |
| div_reg_o | output | 7 | Packed divider field value {M, N} |

## Verification
The hardest case to reach is a tie between an early candidate and a later one with the same rate but a different (M, N) pair. This happens when (M + 1) * 2^N products coincide, such as M = 1, N = 0 against M = 0, N = 1. The stimulus reaches it with a small core rate chosen so that these two pairs give the same non-exact rate just below the target. That case tests both the strict comparison and the visit order. Other directed runs cover the early exit, a core rate too high for any candidate, and a start pulse landing mid-search. Random runs with a fixed seed cover both exponent conventions. About a third of them use targets derived from an exact candidate, so that early exits happen at random points in the sweep.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } bcf_state_e;
endpackage

// File: rtl/bcf_restoring_div.sv
module bcf_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  den_q;
  logic [W-1:0]  num_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {rem_q[W-1:0], quo[W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      num_q <= '0;
      quo   <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quo   <= num;
        num_q <= num;
        den_q <= den;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? (trial - {1'b0, den_q}) : trial;
        quo   <= {quo[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        done  <= (cnt_q == CW'(1));
      end
    end
  end

  // Quotient bound check used by R1/R2: q*d <= n < (q+1)*d
  logic [2*W-1:0] prod_chk;
  assign prod_chk = {{W{1'b0}}, quo} * {{W{1'b0}}, den_q};

  a_r1_quotient_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (done && den_q != '0) |-> (prod_chk <= {{W{1'b0}}, num_q}) &&
                              (({{W{1'b0}}, num_q} - prod_chk) < {{W{1'b0}}, den_q}));
endmodule

// File: rtl/bcf_candidate_gen.sv
module bcf_candidate_gen #(
  parameter int W     = 32,
  parameter int M_W   = 4,
  parameter int N_W   = 3,
  parameter int SCALE = 10
) (
  input  logic [M_W-1:0] m,
  input  logic [N_W-1:0] n,
  input  logic           base0,
  output logic [W-1:0]   divisor
);
  localparam int SH_W = N_W + 1;

  logic [W-1:0]    lin;
  logic [SH_W-1:0] shift;

  assign lin   = W'(SCALE) * (W'(m) + W'(1));
  assign shift = base0 ? SH_W'(n) : (SH_W'(n) + SH_W'(1));
  assign divisor = lin << shift;
endmodule

// File: rtl/bcf_best_track.sv
module bcf_best_track #(
  parameter int W   = 32,
  parameter int M_W = 4,
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           eval,
  input  logic [W-1:0]   target,
  input  logic [W-1:0]   rate,
  input  logic [M_W-1:0] m,
  input  logic [N_W-1:0] n,
  output logic           hit,
  output logic           any,
  output logic [M_W-1:0] best_m,
  output logic [N_W-1:0] best_n
);
  logic [W:0]   best_q;
  logic [W-1:0] diff;
  logic         accept;

  assign diff   = target - rate;
  assign accept = eval && (target >= rate) && ({1'b0, diff} < best_q);
  assign hit    = accept && (diff == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_q <= {1'b1, {W{1'b0}}};
      any    <= 1'b0;
      best_m <= '0;
      best_n <= '0;
    end else if (clear) begin
      best_q <= {1'b1, {W{1'b0}}};
      any    <= 1'b0;
      best_m <= '0;
      best_n <= '0;
    end else if (accept) begin
      best_q <= {1'b0, diff};
      any    <= 1'b1;
      best_m <= m;
      best_n <= n;
    end
  end

  // R3: the kept difference never grows during a search
  a_r3_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clear) && !clear) |-> (best_q <= $past(best_q)));
endmodule

// File: rtl/busclk_factor_search.sv
module busclk_factor_search #(
  parameter int FREQ_W = 32,
  parameter int M_W    = 4,
  parameter int N_W    = 3,
  parameter int SCALE  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] core_hz_i,
  input  logic [FREQ_W-1:0] target_hz_i,
  input  logic              base0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic [M_W-1:0]    m_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W+N_W-1:0] div_reg_o
);
  import bcf_pkg::*;

  localparam logic [M_W-1:0] M_LAST = {M_W{1'b1}};
  localparam logic [N_W-1:0] N_LAST = {N_W{1'b1}};

  bcf_state_e        state_q;
  logic [FREQ_W-1:0] core_q;
  logic [FREQ_W-1:0] target_q;
  logic              base0_q;
  logic [M_W-1:0]    m_cur;
  logic [N_W-1:0]    n_cur;
  logic              clear;
  logic              div_go;
  logic              div_done;
  logic [FREQ_W-1:0] divisor;
  logic [FREQ_W-1:0] rate;
  logic              hit;
  logic              any;
  logic [M_W-1:0]    best_m;
  logic [N_W-1:0]    best_n;
  logic              last_cand;

  assign clear     = (state_q == ST_IDLE) && start_i;
  assign div_go    = (state_q == ST_ISSUE);
  assign last_cand = (m_cur == M_LAST) && (n_cur == N_LAST);

  bcf_candidate_gen #(
    .W(FREQ_W), .M_W(M_W), .N_W(N_W), .SCALE(SCALE)
  ) u_cand (
    .m(m_cur), .n(n_cur), .base0(base0_q), .divisor(divisor)
  );

  bcf_restoring_div #(.W(FREQ_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(core_q), .den(divisor),
    .quo(rate), .done(div_done)
  );

  bcf_best_track #(.W(FREQ_W), .M_W(M_W), .N_W(N_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clear(clear), .eval(div_done),
    .target(target_q), .rate(rate), .m(m_cur), .n(n_cur),
    .hit(hit), .any(any), .best_m(best_m), .best_n(best_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      core_q    <= '0;
      target_q  <= '0;
      base0_q   <= 1'b0;
      m_cur     <= '0;
      n_cur     <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      found_o   <= 1'b0;
      m_o       <= '0;
      n_o       <= '0;
      div_reg_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            core_q   <= core_hz_i;
            target_q <= target_hz_i;
            base0_q  <= base0_i;
            m_cur    <= '0;
            n_cur    <= '0;
            busy_o   <= 1'b1;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            if (hit || last_cand) begin
              state_q <= ST_FIN;
            end else begin
              state_q <= ST_ISSUE;
              if (m_cur == M_LAST) begin
                m_cur <= '0;
                n_cur <= n_cur + 1'b1;
              end else begin
                m_cur <= m_cur + 1'b1;
              end
            end
          end
        end
        ST_FIN: begin
          found_o   <= any;
          m_o       <= any ? best_m : '0;
          n_o       <= any ? best_n : '0;
          div_reg_o <= any ? {best_m, best_n} : '0;
          done_o    <= 1'b1;
          busy_o    <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_busy_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> ($stable(div_reg_o) && $stable(found_o)));

  a_r5_empty_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !found_o) |-> (div_reg_o == '0));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/busclk_factor_search_tb_top.sv
`timescale 1ns/1ps
module busclk_factor_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] core_hz_i = '0;
  logic [31:0] target_hz_i = '0;
  logic        base0_i = 1'b0;
  logic        busy_o, done_o, found_o;
  logic [3:0]  m_o;
  logic [2:0]  n_o;
  logic [6:0]  div_reg_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  busclk_factor_search dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_hz_i(core_hz_i),
    .target_hz_i(target_hz_i), .base0_i(base0_i), .busy_o(busy_o),
    .done_o(done_o), .found_o(found_o), .m_o(m_o), .n_o(n_o),
    .div_reg_o(div_reg_o)
  );

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic ok, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Returns {found, M[3:0], N[2:0]}; zero when nothing qualifies.
  function automatic logic [7:0] model(input logic [31:0] core, input logic [31:0] req,
                                       input logic alt);
    logic [32:0] best = 33'h1_0000_0000;
    logic [3:0]  bm = '0;
    logic [2:0]  bn = '0;
    logic        f = 1'b0;
    logic        stop = 1'b0;
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 16; m++) begin
        if (!stop) begin
          logic [31:0] d;
          logic [31:0] fq;
          d  = 32'(10 * (m + 1)) << (alt ? n : n + 1);
          fq = core / d;
          if (req >= fq && {1'b0, req - fq} < best) begin
            best = {1'b0, req - fq};
            bm = 4'(m);
            bn = 3'(n);
            f = 1'b1;
          end
          if (best == 33'd0) stop = 1'b1;
        end
      end
    end
    return f ? {1'b1, bm, bn} : 8'h00;
  endfunction

  task automatic pulse_start(input logic [31:0] core, input logic [31:0] req,
                             input logic alt);
    @(negedge clk);
    core_hz_i = core; target_hz_i = req; base0_i = alt; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input string tag, input logic [7:0] exp);
    chk({tag, " found"}, found_o == exp[7], 32'(found_o), 32'(exp[7]));
    chk({tag, " M"}, m_o == exp[6:3], 32'(m_o), 32'(exp[6:3]));
    chk({tag, " N"}, n_o == exp[2:0], 32'(n_o), 32'(exp[2:0]));
    // R6: N in bits 2:0, M in bits 6:3
    chk("R6 packing", div_reg_o == exp[6:0], 32'(div_reg_o), 32'(exp[6:0]));
  endtask

  task automatic run(input string tag, input logic [31:0] core, input logic [31:0] req,
                     input logic alt, output int lat);
    logic [7:0] exp;
    exp = model(core, req, alt);
    pulse_start(core, req, alt);
    chk("R7 busy after start", busy_o == 1'b1, 32'(busy_o), 32'd1);
    wait_done(lat);
    chk("R7 busy low at done", busy_o == 1'b0, 32'(busy_o), 32'd0);
    check_result(tag, exp);
    @(negedge clk);
    chk("R7 done single cycle", done_o == 1'b0, 32'(done_o), 32'd0);
  endtask

  initial begin
    int lat;
    logic [7:0] snap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy_o == 1'b0, 32'(busy_o), 32'd0);
    chk("R10 done", done_o == 1'b0, 32'(done_o), 32'd0);
    chk("R10 result", {found_o, div_reg_o} == 8'h00, 32'({found_o, div_reg_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 typical default-mode search
    run("R1 default 166MHz/100kHz", 32'd166_666_666, 32'd100_000, 1'b0, lat);
    // R2 alternate exponent convention
    run("R2 base0 24MHz/100kHz", 32'd24_000_000, 32'd100_000, 1'b1, lat);
    run("R2 base0 100MHz/400kHz", 32'd100_000_000, 32'd400_000, 1'b1, lat);

    // R4 exact at first candidate: 100e6/20 = 5e6
    run("R4 exact first", 32'd100_000_000, 32'd5_000_000, 1'b0, lat);
    chk("R4 early exit latency", lat < 60, 32'(lat), 32'd60);
    chk("R4 chose M0N0", div_reg_o == 7'h00 && found_o, 32'(div_reg_o), 32'd0);

    // R3 tie: core 4000, target 101; (M1,N0) and (M0,N1) both give 100
    run("R3 tie order", 32'd4000, 32'd101, 1'b0, lat);
    chk("R3 earliest wins", m_o == 4'd1 && n_o == 3'd0, 32'(div_reg_o), 32'h08);

    // R5 every candidate above the target
    run("R5 none", 32'hFFFF_FFFF, 32'd1000, 1'b0, lat);
    chk("R5 not found", found_o == 1'b0 && div_reg_o == 7'h00,
        32'({found_o, div_reg_o}), 32'd0);

    // R8 start during a search is ignored
    snap = model(32'd50_000_000, 32'd333_333, 1'b0);
    pulse_start(32'd50_000_000, 32'd333_333, 1'b0);
    repeat (10) @(negedge clk);
    core_hz_i = 32'd7_000_000; target_hz_i = 32'd12_345; base0_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 still busy", busy_o == 1'b1, 32'(busy_o), 32'd1);
    wait_done(lat);
    check_result("R8 first request kept", snap);

    // R9 hold after done while inputs move
    @(negedge clk);
    core_hz_i = 32'd1; target_hz_i = 32'd0; base0_i = 1'b0;
    repeat (20) @(negedge clk);
    check_result("R9 held", snap);

    // Random stimulus with fixed seed
    for (int i = 0; i < 18; i++) begin
      logic [31:0] core, req;
      logic alt;
      core = 32'd1_000_000 + ($urandom % 32'd400_000_000);
      alt  = 1'($urandom);
      if (i % 3 == 0) begin
        int mm, nn;
        mm = int'($urandom % 16);
        nn = int'($urandom % 8);
        req = core / (32'(10 * (mm + 1)) << (alt ? nn : nn + 1));
      end else begin
        req = 32'd1 + ($urandom % 32'd2_000_000);
      end
      run(alt ? "R2 random" : "R1 random", core, req, alt, lat);
    end

    summary();
  end
endmodule